// File: doc/BRIEF.md
# Mirrored Core-Module Access Router

This block sits between a processor's memory port and a bank of up to eight word-addressed storage modules, each holding 4096 words of 26 bits with two parity bits per word. It steers every processor access to the right module and can run the bank in two ways. In single-copy mode every module holds its own part of the address space, so eight modules give 32K words. In mirrored mode modules work in even/odd pairs that hold identical contents, which halves the capacity to 16K words but lets a read survive a parity fault in one copy.

A processor access is a single request carrying an address, write data, a write flag and the mode. The router raises the request line of each module it needs, holds it until that module acknowledges, and then answers the processor with one response pulse. That pulse carries the read word, an address-error flag and an uncorrectable-error flag. A mirrored read normally touches only the even module of the pair. It goes to the odd module only when the even copy reports a parity error in either syllable.

Top module: `core_bank_router`

## Requirements
- R1: In single-copy mode the module index is the address bits above bit 11 and the module word address is bits 11..0; only that module's request line is raised.
- R2: In mirrored mode the address bits above bit 11 give a pair index p (valid below NMOD/2); module 2p is the primary copy, module 2p+1 the mirror, and the word address is bits 11..0 in both.
- R3: A mirrored write raises the request lines of both modules of the pair with the same word address and data, and it responds only after both modules have acknowledged, in whatever cycles the acknowledges arrive.
- R4: A mirrored read whose primary copy reports no parity error returns the primary data with both error flags low, and it never requests the mirror.
- R5: A mirrored read whose primary copy reports a parity error (either of the module's two parity-error bits, one per 13-bit syllable) then reads the mirror. If the mirror is clean, it returns the mirror data with the uncorrectable flag low.
- R6: A mirrored read in which both copies report a parity error returns the primary copy's data with the uncorrectable flag high.
- R7: A single-copy read whose module reports a parity error returns that module's data with the uncorrectable flag high.
- R8: An address at or beyond the capacity of the mode in use (NMOD*4096 words single-copy, NMOD/2*4096 mirrored) gets a response with the address-error flag high and read data zero, in the cycle after acceptance, and no module request is raised.
- R9: The mode is sampled when a request is accepted and stays fixed until its response. While an access is in flight, req_ready is low and changes on req_valid, the request fields or cfg_duplex have no effect on it.
- R10: During and right after reset no module request is raised, rsp_valid is low and req_ready is high.
- R11: A module request line stays high until that module acknowledges. Module word address, data and write flag are stable while any request line is high. An acknowledge from a module that is not being requested is ignored.
- R12: rsp_valid is a one-cycle pulse in the cycle after the completing acknowledge, and read data is zero on write responses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_duplex | input | 1 | 1 = mirrored mode, 0 = single-copy mode, sampled on acceptance |
| req_valid | input | 1 | Processor request present |
| req_ready | output | 1 | Router idle, request accepted on this edge |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW (15) | Processor word address |
| req_wdata | input | DW (26) | Write word |
| rsp_valid | output | 1 | Response pulse |
| rsp_rdata | output | DW (26) | Read word |
| rsp_addr_err | output | 1 | Address beyond capacity, access rejected |
| rsp_uncorr | output | 1 | No parity-clean copy was available |
| m_req | output | NMOD (8) | Per-module request |
| m_we | output | 1 | Write flag shared by all modules |
| m_addr | output | MAW (12) | Word address shared by all modules |
| m_wdata | output | DW (26) | Write word shared by all modules |
| m_ack | input | NMOD (8) | Per-module acknowledge, read data valid with it |
| m_rdata | input | NMOD*DW (208) | Per-module read word, module i at bits i*DW upward |
| m_perr | input | 2*NMOD (16) | Per-module syllable parity errors, module i at bits 2i+1..2i |

## Verification
A wrong pending mask shows at the module ports straight away. Either a request line for a module outside the computed pair stays high, or a needed line drops before its acknowledge, and the per-clock comparison catches this in the same cycle. A wrong phase or saved-word register only shows when the response pulse arrives, as a word from the wrong copy or a wrong uncorrectable flag. The record of acknowledged modules then shows whether a mirror was touched when it should not have been. A stale mode or capacity decision shows one cycle after acceptance, as a spurious or missing address-error response.

// File: rtl/core_bank_router.sv
module core_bank_router #(
  parameter int NMOD = 8,
  parameter int MAW  = 12,
  parameter int DW   = 26,
  localparam int MW  = $clog2(NMOD),
  localparam int AW  = MAW + MW
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_duplex,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic                 req_write,
  input  logic [AW-1:0]        req_addr,
  input  logic [DW-1:0]        req_wdata,
  output logic                 rsp_valid,
  output logic [DW-1:0]        rsp_rdata,
  output logic                 rsp_addr_err,
  output logic                 rsp_uncorr,
  output logic [NMOD-1:0]      m_req,
  output logic                 m_we,
  output logic [MAW-1:0]       m_addr,
  output logic [DW-1:0]        m_wdata,
  input  logic [NMOD-1:0]      m_ack,
  input  logic [NMOD*DW-1:0]   m_rdata,
  input  logic [2*NMOD-1:0]    m_perr
);
  localparam int SIMP_CAP = NMOD << MAW;
  localparam int DUP_CAP  = (NMOD / 2) << MAW;

  logic            busy, is_wr, dup, mir_ph;
  logic [MW-1:0]   prim;
  logic [NMOD-1:0] pend;
  logic [MAW-1:0]  waddr;
  logic [DW-1:0]   wdata, saved;

  wire  [MW-1:0]   hi        = req_addr[AW-1:MAW];
  wire             in_range  = cfg_duplex ? (int'(req_addr) < DUP_CAP)
                                          : (int'(req_addr) < SIMP_CAP);
  wire  [MW-1:0]   first_mod = cfg_duplex ? {hi[MW-2:0], 1'b0} : hi;
  wire  [MW-1:0]   cur       = mir_ph ? (prim | MW'(1)) : prim;
  wire  [DW-1:0]   rd_sel    = m_rdata[cur*DW +: DW];
  wire             perr_sel  = |m_perr[cur*2 +: 2];
  wire             ack_sel   = m_ack[cur] & pend[cur];
  wire  [NMOD-1:0] left      = pend & ~m_ack;

  assign req_ready = ~busy;
  assign m_req     = pend;
  assign m_we      = is_wr;
  assign m_addr    = waddr;
  assign m_wdata   = wdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0; is_wr <= 1'b0; dup <= 1'b0; mir_ph <= 1'b0;
      prim <= '0; pend <= '0; waddr <= '0; wdata <= '0; saved <= '0;
      rsp_valid <= 1'b0; rsp_rdata <= '0; rsp_addr_err <= 1'b0; rsp_uncorr <= 1'b0;
    end else begin
      rsp_valid    <= 1'b0;
      rsp_rdata    <= '0;
      rsp_addr_err <= 1'b0;
      rsp_uncorr   <= 1'b0;
      if (!busy) begin
        if (req_valid) begin
          if (!in_range) begin
            rsp_valid    <= 1'b1;
            rsp_addr_err <= 1'b1;
          end else begin
            busy   <= 1'b1;
            is_wr  <= req_write;
            dup    <= cfg_duplex;
            prim   <= first_mod;
            mir_ph <= 1'b0;
            waddr  <= req_addr[MAW-1:0];
            wdata  <= req_wdata;
            pend   <= ((cfg_duplex && req_write) ? NMOD'(3) : NMOD'(1)) << first_mod;
          end
        end
      end else if (is_wr) begin
        pend <= left;
        if (left == '0) begin
          busy      <= 1'b0;
          rsp_valid <= 1'b1;
        end
      end else if (ack_sel) begin
        if (!perr_sel) begin
          busy      <= 1'b0;
          pend      <= '0;
          rsp_valid <= 1'b1;
          rsp_rdata <= rd_sel;
        end else if (dup && !mir_ph) begin
          mir_ph <= 1'b1;
          saved  <= rd_sel;
          pend   <= NMOD'(1) << (prim | MW'(1));
        end else begin
          busy       <= 1'b0;
          pend       <= '0;
          rsp_valid  <= 1'b1;
          rsp_uncorr <= 1'b1;
          rsp_rdata  <= mir_ph ? saved : rd_sel;
        end
      end
    end
  end

  logic [NMOD/2-1:0] pair_act;
  always_comb begin
    for (int j = 0; j < NMOD/2; j++) pair_act[j] = |m_req[2*j +: 2];
  end

  p_one_pair_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(pair_act) <= 1);

  p_hold_until_ack_r11: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(m_req & ~m_ack) & ~m_req) == '0));

  p_stable_fields_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (m_req != '0 && $past(m_req) != '0) |-> ($stable(m_addr) && $stable(m_wdata) && $stable(m_we)));

  p_reject_no_access_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_addr_err) |-> (m_req == '0 && $past(m_req) == '0));

  p_uncorr_on_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_uncorr |-> (rsp_valid && !rsp_addr_err));

  p_mode_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(dup));

  p_idle_no_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (m_req == '0));
endmodule

// File: tb/core_bank_router_tb.sv
module core_bank_router_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NM = 8;
  localparam logic [25:0] CORR = 26'h2AAAAAA;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_duplex = 1'b0, req_valid = 1'b0, req_write = 1'b0;
  logic [14:0] req_addr = '0;
  logic [25:0] req_wdata = '0;
  logic req_ready, rsp_valid, rsp_addr_err, rsp_uncorr, m_we;
  logic [25:0] rsp_rdata, m_wdata;
  logic [NM-1:0] m_req;
  logic [11:0] m_addr;
  logic [NM-1:0] m_ack = '0;
  logic [NM*26-1:0] m_rdata = '0;
  logic [2*NM-1:0] m_perr = '0;

  core_bank_router dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_duplex(cfg_duplex),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_addr_err(rsp_addr_err),
    .rsp_uncorr(rsp_uncorr), .m_req(m_req), .m_we(m_we), .m_addr(m_addr),
    .m_wdata(m_wdata), .m_ack(m_ack), .m_rdata(m_rdata), .m_perr(m_perr));

  always #(CLK_PERIOD/2) clk = ~clk;

  int nvec = 0, nfail = 0;
  logic [25:0] mem  [int];
  logic [25:0] gold [int];
  int lat [NM] = '{0, 2, 1, 3, 0, 4, 1, 0};
  int cnt [NM];
  logic [NM-1:0] perr_inj = '0, allow = '0, acked = '0;
  logic [11:0] exp_word = '0;
  logic exp_we = 1'b0;
  string cur_tag = "R10";

  function automatic logic [25:0] rd(ref logic [25:0] a [int], input int k);
    return a.exists(k) ? a[k] : 26'h0;
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    nvec++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // module responders and per-clock comparison against the model (R11)
  always @(negedge clk) begin
    if (rst_n) begin
      chk((m_req & ~allow) == '0, cur_tag, "m_req outside expected set", 64'(m_req), 64'(allow));
      if (m_req != '0)
        chk(m_addr == exp_word && m_we == exp_we, "R11", "module addr/we",
            {51'(m_addr), m_we}, {51'(exp_word), exp_we});
    end
    for (int i = 0; i < NM; i++) begin
      if (m_ack[i]) m_ack[i] = 1'b0;
      else if (rst_n && m_req[i]) begin
        if (cnt[i] >= lat[i]) begin
          cnt[i] = 0;
          m_ack[i] = 1'b1;
          acked[i] = 1'b1;
          if (m_we) mem[i*4096 + int'(m_addr)] = m_wdata;
          m_rdata[i*26 +: 26] = rd(mem, i*4096 + int'(m_addr)) ^ (perr_inj[i] ? CORR : 26'h0);
          m_perr[i*2 +: 2] = perr_inj[i] ? 2'(1 << (i % 2)) : 2'b00;
        end else cnt[i]++;
      end else cnt[i] = 0;
    end
  end

  task automatic op(input bit wr, input int addr, input logic [25:0] d,
                    input bit dup, input logic [NM-1:0] pe, input string tag);
    int hi = addr / 4096, word = addr % 4096;
    bit inr = dup ? (hi < NM/2) : (hi < NM);
    int pm = dup ? 2*hi : hi, mm = pm + 1;
    logic [NM-1:0] a_m = '0, e_acks = '0;
    logic [25:0] e_data = '0;
    bit e_err = !inr, e_unc = 0, seen = 0;
    if (inr) begin
      if (wr) begin
        a_m[pm] = 1'b1;
        if (dup) a_m[mm] = 1'b1;
        e_acks = a_m;
        gold[pm*4096 + word] = d;
        if (dup) gold[mm*4096 + word] = d;
      end else if (!dup || !pe[pm]) begin
        a_m[pm] = 1'b1; e_acks = a_m;
        e_unc = pe[pm];
        e_data = rd(gold, pm*4096 + word) ^ (pe[pm] ? CORR : 26'h0);
      end else begin
        a_m[pm] = 1'b1; a_m[mm] = 1'b1; e_acks = a_m;
        e_unc = pe[mm];
        e_data = pe[mm] ? (rd(gold, pm*4096 + word) ^ CORR) : rd(gold, mm*4096 + word);
      end
    end
    @(negedge clk);
    chk(req_ready == 1'b1, "R9", "ready before request", 64'(req_ready), 64'd1);
    perr_inj = pe; allow = a_m; acked = '0; exp_word = 12'(word); exp_we = wr; cur_tag = tag;
    req_valid = 1'b1; req_write = wr; req_addr = 15'(addr); req_wdata = d; cfg_duplex = dup;
    for (int c = 0; c < 500; c++) begin
      @(negedge clk);
      if (rsp_valid) begin seen = 1; break; end
      // in-flight changes must be ignored (R9)
      req_addr = 15'(addr) ^ 15'h1555; req_write = ~wr; req_wdata = ~d; cfg_duplex = ~dup;
      chk(req_ready == 1'b0 || c == 0, "R9", "ready while busy", 64'(req_ready), 64'd0);
    end
    req_valid = 1'b0;
    chk(seen, tag, "response arrived", 64'(seen), 64'd1);
    chk(rsp_rdata == e_data, tag, "read data", 64'(rsp_rdata), 64'(e_data));
    chk(rsp_addr_err == e_err, tag, "addr error flag", 64'(rsp_addr_err), 64'(e_err));
    chk(rsp_uncorr == e_unc, tag, "uncorrectable flag", 64'(rsp_uncorr), 64'(e_unc));
    chk(acked == e_acks, tag, "modules acknowledged", 64'(acked), 64'(e_acks));
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R12", "response is one pulse", 64'(rsp_valid), 64'd0);
    allow = '0; perr_inj = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    for (int i = 0; i < NM; i++) cnt[i] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(m_req == '0 && rsp_valid == 1'b0 && req_ready == 1'b1, "R10", "reset state",
        {m_req, rsp_valid, req_ready}, 64'b01);
    rst_n = 1'b1;
    @(negedge clk);
    chk(m_req == '0 && rsp_valid == 1'b0 && req_ready == 1'b1, "R10", "after reset",
        {m_req, rsp_valid, req_ready}, 64'b01);
    op(1, 'h0005, 26'h1000001, 0, '0, "R1");
    op(1, 'h1234, 26'h0ABCDEF, 0, '0, "R1");
    op(1, 'h7FFF, 26'h3FFFFFF, 0, '0, "R1");
    op(0, 'h0005, '0, 0, '0, "R1");
    op(0, 'h1234, '0, 0, '0, "R1");
    op(0, 'h7FFF, '0, 0, '0, "R12");
    op(1, 'h0234, 26'h0000123, 0, '0, "R12");
    op(0, 'h1234, '0, 0, 8'b0000_0010, "R7");
    op(1, 'h0010, 26'h2468ACE, 1, '0, "R3");
    op(1, 'h2ABC, 26'h1357BDF, 1, '0, "R3");
    op(1, 'h3FFF, 26'h0F0F0F0, 1, '0, "R2");
    op(0, 'h2ABC, '0, 1, '0, "R4");
    op(0, 'h3FFF, '0, 1, 8'b1000_0000, "R4");
    op(0, 'h2ABC, '0, 1, 8'b0001_0000, "R5");
    op(0, 'h0010, '0, 1, 8'b0000_0011, "R6");
    op(0, 'h1010, '0, 0, '0, "R2");
    op(1, 'h4000, 26'h1111111, 1, '0, "R8");
    op(0, 'h7123, '0, 1, '0, "R8");
    op(0, 'h4000, '0, 0, '0, "R8");
    op(0, 'h0010, '0, 1, '0, "R9");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule